// File: doc/BRIEF.md
# Keyed Clock-Source Select Register

This block is a 16-bit clock-source selection register on a byte-write bus. Its two guarded fields cannot be changed by an ordinary write. The target-source field sits in the high byte. The start bit sits in the low byte. Each field only accepts a write that comes directly after its own two-byte key, and each key is written to that field's byte lane. A key opens exactly one following bus write. If any other write falls between the two key bytes, the key is cancelled.

Setting the start bit leaves a switch pending. The request is held until the ready input of the chosen source goes high. On that edge the current-source field takes the target value and the start bit clears. Software reads the start bit as a busy flag, and a 0 means the switch has finished. A read-only lock bit shows the registered state of the PLL lock input, so a switch that never finishes can be diagnosed. If the target is the source already in use, the switch finishes on the next cycle.

Two copies of a key-tracking state machine run side by side, one per byte lane. Each has the states KEY_IDLE, KEY_HALF and KEY_OPEN. Their transitions are:
- first key byte: KEY_IDLE to KEY_HALF.
- second key byte: KEY_HALF to KEY_OPEN.
- a stray write: KEY_HALF to KEY_IDLE.
- the single consuming write: KEY_OPEN to KEY_IDLE.

The switch state machine has the states SW_IDLE and SW_PEND. Its transitions are:
- start: SW_IDLE to SW_PEND.
- done: SW_PEND to SW_IDLE, when the target is ready or is already current.

Top module: `keyed_clksel`

## Requirements
- R1: After reset the read-back is 16'h1100. Current source (bits 14:12) and target (bits 10:8) both hold the default source 1. The start bit (bit 0) is 0, the lock bit (bit 5) is 0, and all other bits read 0.
- R2: Writing 8'h78 and then 8'h9A to the high lane (`bus_hi`=1) opens that lane. The next write, if it goes to the high lane, loads target bits 10:8 from data bits 2:0.
- R3: Writing 8'h46 and then 8'h57 to the low lane (`bus_hi`=0) opens that lane. The next write, if it goes to the low lane with data bit 0 = 1, sets the start bit.
- R4: A write to either lane that is not directly preceded by that lane's complete key leaves the target field and the start bit unchanged.
- R5: Any bus write between the first and second key byte cancels the key, so the following writes have no effect.
- R6: An opened key is used up by the next bus write on any lane. Later writes, and a consuming write on the wrong lane, change nothing.
- R7: While the start bit is 1, the target differs from the current source, and the target's ready input is low, the start bit stays 1 and the current source is unchanged.
- R8: On the edge where the start bit is 1 and `src_ready[target]` is high, the current field and `cur_src` take the target value and the start bit clears.
- R9: When the start bit is set with target equal to current source, the bit reads 1 for one cycle and 0 on the next.
- R10: The lock bit (bit 5) shows `pll_lock` as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_hi | input | 1 | Byte lane: 1 high byte, 0 low byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 16 | Register read-back |
| src_ready | input | 8 | Ready flag of each clock source, indexed by source code |
| pll_lock | input | 1 | PLL lock indication |
| cur_src | output | 3 | Source code currently selected |

## Verification
A key state machine stuck in KEY_OPEN shows up on the bus: a write that should be ignored changes bits 10:8 or bit 0 in the read-back that follows. A key machine that never opens leaves those bits stuck. In both cases the fault is visible one cycle after the offending write. A switch machine stuck in SW_PEND keeps bit 0 high after the ready input has risen. A switch machine that leaves SW_PEND too early clears bit 0 while ready is low. Both faults appear within one cycle of the ready change, and `cur_src` disagrees with bits 14:12 of the read-back expectation on that same cycle.

// File: rtl/keyed_clksel_pkg.sv
package keyed_clksel_pkg;
    localparam int SEL_W = 3;
    localparam int NSRC  = 1 << SEL_W;
    localparam int DW    = 8;
    localparam int LOCK_BIT = 5;

    typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_OPEN} key_st_e;
    typedef enum logic {SW_IDLE, SW_PEND} sw_st_e;
endpackage

// File: rtl/keyed_clksel_key.sv
module keyed_clksel_key
    import keyed_clksel_pkg::*;
#(
    parameter logic [DW-1:0] KEY_A = 8'h00,
    parameter logic [DW-1:0] KEY_B = 8'h00,
    parameter bit            LANE  = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          hi,
    input  logic [DW-1:0] wdata,
    output logic          grant
);
    key_st_e state_q, state_d;
    logic    on_lane;

    assign on_lane = wr && (hi == LANE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE: if (on_lane && wdata == KEY_A) state_d = KEY_HALF;
            KEY_HALF: begin
                if (wr) begin
                    if (on_lane && wdata == KEY_B)      state_d = KEY_OPEN;
                    else if (on_lane && wdata == KEY_A) state_d = KEY_HALF;
                    else                                state_d = KEY_IDLE;
                end
            end
            KEY_OPEN: if (wr) state_d = KEY_IDLE;
            default:  state_d = KEY_IDLE;
        endcase
    end

    always_comb begin
        grant = (state_q == KEY_OPEN) && on_lane;
    end
endmodule

// File: rtl/keyed_clksel_sw.sv
module keyed_clksel_sw
    import keyed_clksel_pkg::*;
#(
    parameter logic [SEL_W-1:0] RST_SRC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [SEL_W-1:0] target,
    input  logic [NSRC-1:0]  ready,
    output logic             busy,
    output logic [SEL_W-1:0] cur
);
    sw_st_e           state_q, state_d;
    logic [SEL_W-1:0] cur_q, cur_d;
    logic             finish;

    assign finish = (target == cur_q) || ready[target];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            cur_q   <= RST_SRC;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        unique case (state_q)
            SW_IDLE: if (go) state_d = SW_PEND;
            SW_PEND: if (finish) begin
                state_d = SW_IDLE;
                cur_d   = target;
            end
            default: state_d = SW_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == SW_PEND);
        cur  = cur_q;
    end
endmodule

// File: rtl/keyed_clksel.sv
module keyed_clksel
    import keyed_clksel_pkg::*;
#(
    parameter logic [SEL_W-1:0] RST_SRC = 3'd1,
    parameter logic [DW-1:0]    HI_KEY_A = 8'h78,
    parameter logic [DW-1:0]    HI_KEY_B = 8'h9A,
    parameter logic [DW-1:0]    LO_KEY_A = 8'h46,
    parameter logic [DW-1:0]    LO_KEY_B = 8'h57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_hi,
    input  logic [DW-1:0]     bus_wdata,
    output logic [2*DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   src_ready,
    input  logic              pll_lock,
    output logic [SEL_W-1:0]  cur_src
);
    logic             hi_grant, lo_grant;
    logic             sw_busy;
    logic [SEL_W-1:0] tgt_q, cur_w;
    logic             lock_q;

    keyed_clksel_key #(.KEY_A(HI_KEY_A), .KEY_B(HI_KEY_B), .LANE(1'b1)) u_hi_key (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .hi(bus_hi), .wdata(bus_wdata), .grant(hi_grant)
    );

    keyed_clksel_key #(.KEY_A(LO_KEY_A), .KEY_B(LO_KEY_B), .LANE(1'b0)) u_lo_key (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .hi(bus_hi), .wdata(bus_wdata), .grant(lo_grant)
    );

    keyed_clksel_sw #(.RST_SRC(RST_SRC)) u_sw (
        .clk(clk), .rst_n(rst_n), .go(lo_grant && bus_wdata[0]),
        .target(tgt_q), .ready(src_ready), .busy(sw_busy), .cur(cur_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= RST_SRC;
            lock_q <= 1'b0;
        end else begin
            lock_q <= pll_lock;
            if (hi_grant) tgt_q <= bus_wdata[SEL_W-1:0];
        end
    end

    always_comb begin
        bus_rdata           = '0;
        bus_rdata[0]        = sw_busy;
        bus_rdata[LOCK_BIT] = lock_q;
        bus_rdata[DW +: SEL_W]     = tgt_q;
        bus_rdata[DW+4 +: SEL_W]   = cur_w;
        cur_src             = cur_w;
    end
endmodule

// File: rtl/keyed_clksel_chk.sv
module keyed_clksel_chk
    import keyed_clksel_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_hi,
    input logic [DW-1:0]    bus_wdata,
    input logic [2*DW-1:0]  bus_rdata,
    input logic [NSRC-1:0]  src_ready,
    input logic             pll_lock,
    input logic [SEL_W-1:0] cur_src
);
    logic [SEL_W-1:0] tgt, cur;
    logic             busy;
    assign tgt  = bus_rdata[DW +: SEL_W];
    assign cur  = bus_rdata[DW+4 +: SEL_W];
    assign busy = bus_rdata[0];

    p_start_needs_low_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && !bus_hi && bus_wdata[0]));

    p_target_needs_high_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tgt) |-> $past(bus_wr && bus_hi));

    p_hold_without_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tgt != cur && !src_ready[tgt]) |=> (busy && $stable(cur)));

    p_finish_on_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src_ready[tgt]) |=> (!busy && cur == $past(tgt)));

    p_idle_keeps_current_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(cur));

    p_same_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tgt == cur) |=> !busy);

    p_lock_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> bus_rdata[LOCK_BIT] == $past(pll_lock));

    p_port_matches_field_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_src == cur);
endmodule

bind keyed_clksel keyed_clksel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_hi(bus_hi), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_ready(src_ready), .pll_lock(pll_lock), .cur_src(cur_src)
);

// File: tb/keyed_clksel_bench.sv
module keyed_clksel_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_hi = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [15:0] bus_rdata;
    logic [7:0]  src_ready = 8'h00;
    logic        pll_lock = 1'b0;
    logic [2:0]  cur_src;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [2:0] m_cur = 3'd1, m_tgt = 3'd1;
    logic       m_busy = 1'b0, m_lock = 1'b0;

    keyed_clksel u_keyed_clksel (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_hi(bus_hi), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_ready(src_ready), .pll_lock(pll_lock), .cur_src(cur_src)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] expect_rd();
        return {1'b0, m_cur, 1'b0, m_tgt, 2'b00, m_lock, 4'b0000, m_busy};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(bit hi, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_hi = hi; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 readback", bus_rdata, 16'h1100);
        check("R1 cur_src", {13'd0, cur_src}, 16'd1);
    endtask

    task automatic t_unguarded();
        wr(1'b1, 8'h05);
        check("R4 high write ignored", bus_rdata, expect_rd());
        wr(1'b0, 8'h01);
        check("R4 low write ignored", bus_rdata, expect_rd());
    endtask

    task automatic t_hi_unlock();
        wr(1'b1, 8'h78); wr(1'b1, 8'h9A); wr(1'b1, 8'h05);
        m_tgt = 3'd5;
        check("R2 target loaded", bus_rdata, expect_rd());
    endtask

    task automatic t_broken_key();
        wr(1'b1, 8'h78); wr(1'b0, 8'h00); wr(1'b1, 8'h9A); wr(1'b1, 8'h03);
        check("R5 interrupted high key", bus_rdata, expect_rd());
        wr(1'b0, 8'h46); wr(1'b1, 8'h00); wr(1'b0, 8'h57); wr(1'b0, 8'h01);
        check("R5 interrupted low key", bus_rdata, expect_rd());
    endtask

    task automatic t_one_shot();
        wr(1'b1, 8'h78); wr(1'b1, 8'h9A); wr(1'b1, 8'h02);
        m_tgt = 3'd2;
        check("R2 second unlock write", bus_rdata, expect_rd());
        wr(1'b1, 8'h06);
        check("R6 key used up", bus_rdata, expect_rd());
        wr(1'b1, 8'h78); wr(1'b1, 8'h9A); wr(1'b0, 8'h00); wr(1'b1, 8'h04);
        check("R6 consumed by other lane", bus_rdata, expect_rd());
    endtask

    task automatic t_pending();
        wr(1'b0, 8'h46); wr(1'b0, 8'h57); wr(1'b0, 8'h01);
        m_busy = 1'b1;
        check("R3 start bit set", bus_rdata, expect_rd());
        for (int i = 0; i < 3; i++) @(negedge clk);
        check("R7 still pending", bus_rdata, expect_rd());
        src_ready = 8'h01 << 2;
        @(negedge clk);
        m_busy = 1'b0; m_cur = 3'd2;
        check("R8 switch done", bus_rdata, expect_rd());
        check("R8 cur_src", {13'd0, cur_src}, 16'd2);
        src_ready = 8'h00;
    endtask

    task automatic t_same_src();
        wr(1'b0, 8'h46); wr(1'b0, 8'h57); wr(1'b0, 8'h01);
        m_busy = 1'b1;
        check("R9 busy one cycle", bus_rdata, expect_rd());
        @(negedge clk);
        m_busy = 1'b0;
        check("R9 done next cycle", bus_rdata, expect_rd());
    endtask

    task automatic t_lock();
        pll_lock = 1'b1;
        @(negedge clk);
        m_lock = 1'b1;
        check("R10 lock high", bus_rdata, expect_rd());
        pll_lock = 1'b0;
        @(negedge clk);
        m_lock = 1'b0;
        check("R10 lock low", bus_rdata, expect_rd());
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unguarded();
        t_hi_unlock();
        t_broken_key();
        t_one_shot();
        t_pending();
        t_same_src();
        t_lock();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule